// File: doc/BRIEF.md
# Host-to-Controller Mailbox with Doorbell

This block is a small register-mapped mailbox shared by a host processor and a controller processor. The host reaches it over a single-cycle register bus. To post a request, it fills a write-data area and then writes a command word. Accepting that command word sets a busy flag and sends a one-cycle doorbell pulse to the controller. The controller sees the latched command word, the write-data contents and a byte-valid mask. The mask is derived from the length field that the command word declares.

The controller answers by loading words into a response area that the host can read. It then pulses a done strobe, which carries an error flag and an 8-bit error code. The done strobe clears busy. If the accepted command asked for notification on completion, the host also gets a single-cycle completion pulse, which it never has to acknowledge. The host can poll instead by reading the status word, which reports busy, error, the command id, a fixed initiator id and the error code.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset, busy, error, error code, command id, doorbell and completion outputs are all zero, and a status read at offset 0x04 returns only the initiator id in bits 15:8 (0x00005A00 by default).
- R2: A host write to offset 0x00 while not busy has these effects on the next clock edge. It latches the full 32-bit word on `ctl_cmd_o`, sets busy, and raises `ctl_doorbell_o` for exactly one cycle.
- R3: A host write to offset 0x00 while busy is ignored: no doorbell pulse, and `ctl_cmd_o` keeps its value.
- R4: A done strobe while busy clears busy on the next edge and loads the error flag and the error code. The status word is laid out as follows: bits 23:16 hold the error code, bits 15:8 the initiator id, bits 7:4 the command id (command bits 15:12), bit 1 the error flag and bit 0 busy; all other bits read zero.
- R5: The completion output pulses for one cycle, on the edge after an accepted done strobe, only when bit 8 of the latched command word is 1.
- R6: Host writes to 0x80 + 4*i update word i of the write area through per-byte enables (`hbe_i[k]` covers bits 8k+7:8k), which is visible on `ctl_wbuf_o` with word i in bits 32i+31:32i. Host reads of the write area, of offset 0x00 and of unmapped offsets return zero.
- R7: Bit j of `ctl_wmask_o` is 1 exactly when the command length field (bits 23:16) exceeds j, so that lengths of 16 or more set all 16 bits.
- R8: A controller load of word i into the response area can be read back by the host as a word at offset 0x90 + 4*i.
- R9: A host read with `hbyte_i` set returns the byte addressed by `haddr_i[1:0]` in bits 7:0, with zero in bits 31:8.
- R10: A done strobe while not busy has no effect: no completion pulse, and the status word is unchanged.
- R11: Host writes to the status word or the response area change nothing, and in particular do not start a command.
- R12: An accepted command clears the error flag and the error code that the previous done strobe left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Host access valid this cycle |
| hwr_i | input | 1 | Host access is a write (1) or read (0) |
| hbyte_i | input | 1 | Host read returns a single byte |
| haddr_i | input | 8 | Host byte offset |
| hwdata_i | input | 32 | Host write data |
| hbe_i | input | 4 | Host write byte enables (write area only) |
| hrdata_o | output | 32 | Host read data, combinational |
| ctl_doorbell_o | output | 1 | One-cycle pulse when a command is accepted |
| ctl_busy_o | output | 1 | Command outstanding |
| ctl_cmd_o | output | 32 | Latched command word |
| ctl_wbuf_o | output | 128 | Write-area contents, word 0 in the low bits |
| ctl_wmask_o | output | 16 | Valid-byte mask from the command length field |
| ctl_rbuf_we_i | input | 1 | Controller loads one response word |
| ctl_rbuf_idx_i | input | 2 | Response word index |
| ctl_rbuf_data_i | input | 32 | Response word data |
| ctl_done_i | input | 1 | Controller completion strobe |
| ctl_err_i | input | 1 | Error flag taken with done |
| ctl_err_code_i | input | 8 | Error code taken with done |
| host_cmpl_irq_o | output | 1 | One-cycle completion pulse to the host |

## Verification
The bound checker watches the handshake on every cycle. A doorbell only ever appears together with busy. A command write while busy leaves the latched word untouched. A done strobe always clears busy. A completion pulse lasts one cycle and follows a done strobe for a command whose notify bit was set, while a done strobe with nothing outstanding never produces one. The data paths can only be shown by the bench's scenarios: byte-enable merging in the write area, the length-to-mask expansion and its saturation, word and byte readback of the response area, the exact status encoding, and the zero reads of write-only and unmapped offsets.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned HAW = 8;
  localparam int unsigned HDW = 32;

  localparam logic [HAW-1:0] OFF_CMD  = 8'h00;
  localparam logic [HAW-1:0] OFF_STAT = 8'h04;
  localparam logic [HAW-1:0] OFF_WBUF = 8'h80;
  localparam logic [HAW-1:0] OFF_RBUF = 8'h90;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] len;
    logic [3:0] op_id;
    logic [2:0] rsv_lo;
    logic       notify;
    logic [7:0] opcode;
  } cmd_word_t;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] err_code;
    logic [7:0] init_id;
    logic [3:0] op_id;
    logic [1:0] rsv_lo;
    logic       err;
    logic       busy;
  } stat_word_t;
endpackage

// File: rtl/mbx_cmd_status.sv
module mbx_cmd_status
  import mbx_pkg::*;
#(
  parameter logic [7:0] INIT_ID = 8'h5A
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_we_i,
  input  logic [HDW-1:0] cmd_wdata_i,
  input  logic           done_i,
  input  logic           err_i,
  input  logic [7:0]     err_code_i,
  output logic           busy_o,
  output logic           doorbell_o,
  output logic           cmpl_o,
  output cmd_word_t      cmd_o,
  output stat_word_t     stat_o
);
  logic       busy_q, err_q, bell_q, cmpl_q;
  logic [7:0] code_q;
  cmd_word_t  cmd_q;

  logic accept, finish;
  assign accept = cmd_we_i && !busy_q;
  assign finish = done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      cmd_q  <= '0;
      bell_q <= 1'b0;
      cmpl_q <= 1'b0;
    end else begin
      bell_q <= 1'b0;
      cmpl_q <= 1'b0;
      if (accept) begin
        cmd_q  <= cmd_word_t'(cmd_wdata_i);
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
        bell_q <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= err_i;
        code_q <= err_code_i;
        cmpl_q <= cmd_q.notify;
      end
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o.err_code = code_q;
    stat_o.init_id  = INIT_ID;
    stat_o.op_id    = cmd_q.op_id;
    stat_o.err      = err_q;
    stat_o.busy     = busy_q;
  end

  assign busy_o     = busy_q;
  assign doorbell_o = bell_q;
  assign cmpl_o     = cmpl_q;
  assign cmd_o      = cmd_q;
endmodule

// File: rtl/mbx_wbuf.sv
module mbx_wbuf #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned IW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned BYTES = WORDS * 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  input  logic [7:0]         len_i,
  output logic [WORDS*32-1:0] data_o,
  output logic [BYTES-1:0]   mask_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          byte_q <= '0;
        else if (we_i && (idx_i == IW'(w)) && be_i[b])
          byte_q <= wdata_i[8*b +: 8];
      end
      assign data_o[32*w + 8*b +: 8] = byte_q;
    end
  end

  // length above the buffer size saturates to all-valid
  for (genvar j = 0; j < BYTES; j++) begin : g_mask
    assign mask_o[j] = (len_i > 8'(j));
  end
endmodule

// File: rtl/mbx_rbuf.sv
module mbx_rbuf #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [31:0]   wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
  import mbx_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 4,
  parameter logic [7:0]  INIT_ID   = 8'h5A,
  localparam int unsigned IW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int unsigned RB = IW + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hsel_i,
  input  logic                    hwr_i,
  input  logic                    hbyte_i,
  input  logic [HAW-1:0]          haddr_i,
  input  logic [HDW-1:0]          hwdata_i,
  input  logic [3:0]              hbe_i,
  output logic [HDW-1:0]          hrdata_o,
  output logic                    ctl_doorbell_o,
  output logic                    ctl_busy_o,
  output logic [HDW-1:0]          ctl_cmd_o,
  output logic [BUF_WORDS*32-1:0] ctl_wbuf_o,
  output logic [BUF_WORDS*4-1:0]  ctl_wmask_o,
  input  logic                    ctl_rbuf_we_i,
  input  logic [IW-1:0]           ctl_rbuf_idx_i,
  input  logic [HDW-1:0]          ctl_rbuf_data_i,
  input  logic                    ctl_done_i,
  input  logic                    ctl_err_i,
  input  logic [7:0]              ctl_err_code_i,
  output logic                    host_cmpl_irq_o
);
  logic hit_cmd, hit_stat, hit_wbuf, hit_rbuf;
  assign hit_cmd  = haddr_i[HAW-1:2] == OFF_CMD[HAW-1:2];
  assign hit_stat = haddr_i[HAW-1:2] == OFF_STAT[HAW-1:2];
  assign hit_wbuf = haddr_i[HAW-1:RB] == OFF_WBUF[HAW-1:RB];
  assign hit_rbuf = haddr_i[HAW-1:RB] == OFF_RBUF[HAW-1:RB];

  logic wr_en, rd_en;
  assign wr_en = hsel_i && hwr_i;
  assign rd_en = hsel_i && !hwr_i;

  cmd_word_t  cmd;
  stat_word_t stat;

  mbx_cmd_status #(.INIT_ID(INIT_ID)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (wr_en && hit_cmd),
    .cmd_wdata_i(hwdata_i),
    .done_i     (ctl_done_i),
    .err_i      (ctl_err_i),
    .err_code_i (ctl_err_code_i),
    .busy_o     (ctl_busy_o),
    .doorbell_o (ctl_doorbell_o),
    .cmpl_o     (host_cmpl_irq_o),
    .cmd_o      (cmd),
    .stat_o     (stat)
  );
  assign ctl_cmd_o = cmd;

  mbx_wbuf #(.WORDS(BUF_WORDS)) u_wbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en && hit_wbuf),
    .idx_i  (haddr_i[RB-1:2]),
    .be_i   (hbe_i),
    .wdata_i(hwdata_i),
    .len_i  (cmd.len),
    .data_o (ctl_wbuf_o),
    .mask_o (ctl_wmask_o)
  );

  logic [31:0] rbuf_word;
  mbx_rbuf #(.WORDS(BUF_WORDS)) u_rbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl_rbuf_we_i),
    .widx_i (ctl_rbuf_idx_i),
    .wdata_i(ctl_rbuf_data_i),
    .ridx_i (haddr_i[RB-1:2]),
    .rdata_o(rbuf_word)
  );

  logic [31:0] rd_word, rd_shift;
  always_comb begin
    rd_word = '0;
    if (rd_en) begin
      if (hit_stat)      rd_word = stat;
      else if (hit_rbuf) rd_word = rbuf_word;
    end
    rd_shift = rd_word >> {haddr_i[1:0], 3'b000};
    hrdata_o = hbyte_i ? {24'h0, rd_shift[7:0]} : rd_word;
  end
endmodule

// File: rtl/mbx_doorbell_checker.sv
module mbx_doorbell_checker
  import mbx_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hsel_i,
  input logic           hwr_i,
  input logic [HAW-1:0] haddr_i,
  input logic           ctl_done_i,
  input logic           ctl_busy_o,
  input logic           ctl_doorbell_o,
  input logic [HDW-1:0] ctl_cmd_o,
  input logic           host_cmpl_irq_o
);
  logic cmd_wr;
  assign cmd_wr = hsel_i && hwr_i && (haddr_i[HAW-1:2] == OFF_CMD[HAW-1:2]);

  AST_DOORBELL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_doorbell_o |-> ctl_busy_o); // R2
  AST_CMD_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !ctl_busy_o) |=> ctl_doorbell_o); // R2
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && ctl_busy_o) |=> (!ctl_doorbell_o && $stable(ctl_cmd_o))); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_done_i && ctl_busy_o) |=> !ctl_busy_o); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_cmpl_irq_o |-> $past(ctl_done_i && ctl_busy_o && ctl_cmd_o[8])); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_cmpl_irq_o |=> !host_cmpl_irq_o); // R5
  AST_IDLE_DONE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_done_i && !ctl_busy_o) |=> !host_cmpl_irq_o); // R10
endmodule

bind mbx_doorbell_top mbx_doorbell_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .hsel_i         (hsel_i),
  .hwr_i          (hwr_i),
  .haddr_i        (haddr_i),
  .ctl_done_i     (ctl_done_i),
  .ctl_busy_o     (ctl_busy_o),
  .ctl_doorbell_o (ctl_doorbell_o),
  .ctl_cmd_o      (ctl_cmd_o),
  .host_cmpl_irq_o(host_cmpl_irq_o)
);

// File: tb/mbx_doorbell_top_bench.sv
module mbx_doorbell_top_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         hsel_i = 1'b0, hwr_i = 1'b0, hbyte_i = 1'b0;
  logic [7:0]   haddr_i = '0;
  logic [31:0]  hwdata_i = '0;
  logic [3:0]   hbe_i = '0;
  logic [31:0]  hrdata_o;
  logic         ctl_doorbell_o, ctl_busy_o, host_cmpl_irq_o;
  logic [31:0]  ctl_cmd_o;
  logic [127:0] ctl_wbuf_o;
  logic [15:0]  ctl_wmask_o;
  logic         ctl_rbuf_we_i = 1'b0;
  logic [1:0]   ctl_rbuf_idx_i = '0;
  logic [31:0]  ctl_rbuf_data_i = '0;
  logic         ctl_done_i = 1'b0, ctl_err_i = 1'b0;
  logic [7:0]   ctl_err_code_i = '0;

  always #4 clk_i = ~clk_i;

  mbx_doorbell_top u_mbx_doorbell_top (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk_i);
    hsel_i = 1; hwr_i = 1; haddr_i = a; hwdata_i = d; hbe_i = be;
    @(negedge clk_i);
    hsel_i = 0; hwr_i = 0; hbe_i = 0;
  endtask

  task automatic hrd(logic [7:0] a, logic byt, output logic [31:0] d);
    @(negedge clk_i);
    hsel_i = 1; hwr_i = 0; haddr_i = a; hbyte_i = byt;
    #1 d = hrdata_o;
    hsel_i = 0; hbyte_i = 0;
  endtask

  task automatic cdone(logic e, logic [7:0] code);
    @(negedge clk_i);
    ctl_done_i = 1; ctl_err_i = e; ctl_err_code_i = code;
    @(negedge clk_i);
    ctl_done_i = 0; ctl_err_i = 0; ctl_err_code_i = 0;
  endtask

  task automatic cfill(logic [1:0] i, logic [31:0] d);
    @(negedge clk_i);
    ctl_rbuf_we_i = 1; ctl_rbuf_idx_i = i; ctl_rbuf_data_i = d;
    @(negedge clk_i);
    ctl_rbuf_we_i = 0;
  endtask

  // {wr, byte, addr, be, data, expected read}
  localparam int NV = 12;
  localparam logic [77:0] TBL [NV] = '{
    {1'b1, 1'b0, 8'h80, 4'hF, 32'hDEADBEEF, 32'h0},
    {1'b1, 1'b0, 8'h84, 4'h3, 32'h01234567, 32'h0},
    {1'b1, 1'b0, 8'h88, 4'hF, 32'hCAFEF00D, 32'h0},
    {1'b1, 1'b0, 8'h8C, 4'h8, 32'h89ABCDEF, 32'h0},
    {1'b1, 1'b0, 8'h84, 4'hC, 32'hAAAA0000, 32'h0},
    {1'b0, 1'b0, 8'h80, 4'h0, 32'h0, 32'h0},
    {1'b0, 1'b0, 8'h00, 4'h0, 32'h0, 32'h0},
    {1'b1, 1'b0, 8'h04, 4'hF, 32'hFFFFFFFF, 32'h0},
    {1'b0, 1'b0, 8'h04, 4'h0, 32'h0, 32'h00005A00},
    {1'b1, 1'b0, 8'h90, 4'hF, 32'h12345678, 32'h0},
    {1'b0, 1'b0, 8'h90, 4'h0, 32'h0, 32'h0},
    {1'b0, 1'b1, 8'h40, 4'h0, 32'h0, 32'h0}
  };

  initial begin
    logic [31:0] r;
    logic [31:0] exp_wb [4];
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    hrd(8'h04, 0, r); chk("R1 status", r, 32'h00005A00);
    chk("R1 outputs", {29'h0, ctl_busy_o, ctl_doorbell_o, host_cmpl_irq_o}, 32'h0);
    chk("R1 cmd", ctl_cmd_o, 32'h0);

    // vector table: write area merge, zero reads, ignored writes (R6, R11)
    for (int i = 0; i < NV; i++) begin
      if (TBL[i][77]) hwr(TBL[i][75:68], TBL[i][63:32], TBL[i][67:64]);
      else begin
        hrd(TBL[i][75:68], TBL[i][76], r);
        chk("R6/R11 table read", r, TBL[i][31:0]);
      end
    end
    chk("R11 no command started", {31'h0, ctl_busy_o}, 32'h0);
    exp_wb = '{32'hDEADBEEF, 32'hAAAA4567, 32'hCAFEF00D, 32'h89000000};
    for (int w = 0; w < 4; w++) chk("R6 write area word", ctl_wbuf_o[32*w +: 32], exp_wb[w]);

    // R2 accepted command: len 6, id 3, notify, opcode C4
    hwr(8'h00, 32'h000631C4, 4'h0);
    chk("R2 doorbell high", {31'h0, ctl_doorbell_o}, 32'h1);
    chk("R2 cmd latched", ctl_cmd_o, 32'h000631C4);
    chk("R7 mask len 6", {16'h0, ctl_wmask_o}, 32'h0000003F);
    hrd(8'h04, 0, r);
    chk("R2 doorbell one cycle", {31'h0, ctl_doorbell_o}, 32'h0);
    chk("R4 status busy", r, 32'h00005A31);

    // R3 command while busy
    hwr(8'h00, 32'h00102077, 4'hF);
    chk("R3 no doorbell", {31'h0, ctl_doorbell_o}, 32'h0);
    chk("R3 cmd kept", ctl_cmd_o, 32'h000631C4);

    // R8 / R9 response area
    cfill(2'd0, 32'h44332211);
    cfill(2'd1, 32'h88776655);
    cfill(2'd3, 32'hF0E0D0C0);
    hrd(8'h94, 0, r); chk("R8 word 1", r, 32'h88776655);
    hrd(8'h9C, 0, r); chk("R8 word 3", r, 32'hF0E0D0C0);
    hrd(8'h96, 1, r); chk("R9 byte 0x96", r, 32'h00000077);
    hrd(8'h93, 1, r); chk("R9 byte 0x93", r, 32'h00000044);
    hrd(8'h05, 1, r); chk("R9 status byte", r, 32'h0000005A);

    // R4 / R5 done with error, notify set
    cdone(1, 8'h7E);
    chk("R5 completion pulse", {31'h0, host_cmpl_irq_o}, 32'h1);
    hrd(8'h04, 0, r);
    chk("R5 completion one cycle", {31'h0, host_cmpl_irq_o}, 32'h0);
    chk("R4 status after done", r, 32'h007E5A32);

    // R10 done while idle
    cdone(0, 8'h11);
    chk("R10 no completion", {31'h0, host_cmpl_irq_o}, 32'h0);
    hrd(8'h04, 0, r); chk("R10 status unchanged", r, 32'h007E5A32);

    // R12 / R7 saturation: len 20, id 1, no notify
    hwr(8'h00, 32'h00141055, 4'h0);
    chk("R7 mask saturates", {16'h0, ctl_wmask_o}, 32'h0000FFFF);
    hrd(8'h04, 0, r); chk("R12 error cleared", r, 32'h00005A11);
    cdone(0, 8'h00);
    chk("R5 no completion without notify", {31'h0, host_cmpl_irq_o}, 32'h0);
    hrd(8'h04, 0, r); chk("R4 idle status", r, 32'h00005A10);
    hrd(8'h00, 0, r); chk("R6 command reads zero", r, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule